// File: doc/BRIEF.md
# Redundant Product Register with Folding Outputs

This block holds a multiplier result as two partial sums rather than as one finished number. The state is four 16-bit fields: a low field, a first middle field, a high field and a second middle field. The first three fields, concatenated with the high field on top, form one addend. The second middle field, shifted up by 16 bits, forms the other addend. Any consumer that needs the product adds the two and keeps 40 bits. The block does that fold combinationally and presents the result in several shapes to the accumulator datapath.

The multiplier writes all four fields at once through a load port. A clear command loads a non-zero redundant pattern whose two addends still sum to zero modulo 2^40. Reset applies the same pattern.

The block also presents:
- the two unfolded addends, for a flag-only test operation;
- the folded value sign-extended from bit 39, for use as a full ALU source;
- the low 32 bits of the folded value sign-extended from bit 31, for the add-product form.

The multiplier arithmetic itself sits outside this block.

Top module: `prod_redund_reg`

## Requirements
- R1: After reset the fields read low=0x0000, middle-1=0xFFF0, high=0x00FF and middle-2=0x0010.
- R2: A cycle with `clr_i` high loads the pattern of R1 at the next clock edge. `clr_i` takes priority over `wr_i` in the same cycle.
- R3: A cycle with `wr_i` high and `clr_i` low loads the four field inputs at the next clock edge. With both low, the fields hold their value.
- R4: `packed_o` equals ((high[7:0]<<32) | (middle-1<<16) | low) + (middle-2<<16), truncated to 40 bits. The pattern of R1 therefore packs to zero.
- R5: Bits 15:8 of the high field have no effect on `packed_o`, `tst_base_o` or `tst_corr_o`.
- R6: `src_wide_o` is `packed_o` sign-extended from bit 39 to the ALU width (64 bits by default).
- R7: `src_half_o` is `packed_o[31:0]` sign-extended from bit 31 to the ALU width.
- R8: `tst_base_o` equals (high[7:0]<<32)|(middle-1<<16)|low. `tst_corr_o` equals middle-2<<16. Both are 40 bits wide.
- R9: Folding is combinational. The outputs reflect a field write in the same cycle the written fields first appear on the field outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clr_i | input | 1 | Load the redundant zero pattern |
| wr_i | input | 1 | Load the four field inputs |
| wr_lo_i | input | 16 | Low field to load |
| wr_mida_i | input | 16 | First middle field to load |
| wr_hi_i | input | 16 | High field to load |
| wr_midb_i | input | 16 | Second middle field to load |
| fld_lo_o | output | 16 | Stored low field |
| fld_mida_o | output | 16 | Stored first middle field |
| fld_hi_o | output | 16 | Stored high field |
| fld_midb_o | output | 16 | Stored second middle field |
| packed_o | output | 40 | Folded 40-bit product |
| src_wide_o | output | 64 | Folded product sign-extended from bit 39 |
| src_half_o | output | 64 | Low 32 bits of folded product sign-extended from bit 31 |
| tst_base_o | output | 40 | First unfolded addend |
| tst_corr_o | output | 40 | Second unfolded addend |

## Verification
The assertions assume that `clr_i` and `wr_i` are known values in every cycle after reset. They also assume that the field inputs are stable whenever `wr_i` is sampled high.

The stimulus meets these assumptions by driving every input on the falling clock edge. It raises `wr_i` for exactly one cycle per load and otherwise holds the control inputs low. The field values are chosen to reach the corners of the fold:
- a carry out of the middle field into the high field;
- a wrap past bit 39;
- a bit 31 that is set while bit 39 is clear;
- set bits in the ignored upper half of the high field.

// File: rtl/prod_pkg.sv
package prod_pkg;
    localparam int FIELD_W = 16;
    localparam int HI_USED = 8;
    localparam int PACK_W  = 2 * FIELD_W + HI_USED;
    localparam int HALF_W  = 2 * FIELD_W;

    typedef struct packed {
        logic [FIELD_W-1:0] lo;
        logic [FIELD_W-1:0] mida;
        logic [FIELD_W-1:0] hi;
        logic [FIELD_W-1:0] midb;
    } prod_fields_t;

    localparam prod_fields_t CLR_PATTERN = '{
        lo:   16'h0000,
        mida: 16'hFFF0,
        hi:   16'h00FF,
        midb: 16'h0010
    };
endpackage

// File: rtl/prod_fold.sv
module prod_fold
    import prod_pkg::*;
#(
    parameter int FW = FIELD_W,
    parameter int HW = HI_USED,
    localparam int PW = 2 * FW + HW
) (
    input  logic [FW-1:0] lo_i,
    input  logic [FW-1:0] mida_i,
    input  logic [HW-1:0] hi_i,
    input  logic [FW-1:0] midb_i,
    output logic [PW-1:0] base_o,
    output logic [PW-1:0] corr_o,
    output logic [PW-1:0] sum_o
);
    always_comb begin
        base_o = {hi_i, mida_i, lo_i};
        corr_o = {{HW{1'b0}}, midb_i, {FW{1'b0}}};
        sum_o  = base_o + corr_o;
    end
endmodule

// File: rtl/prod_sext.sv
module prod_sext #(
    parameter int IN_W  = 40,
    parameter int OUT_W = 64
) (
    input  logic [IN_W-1:0]  val_i,
    output logic [OUT_W-1:0] ext_o
);
    generate
        if (OUT_W > IN_W) begin : g_widen
            assign ext_o = {{(OUT_W-IN_W){val_i[IN_W-1]}}, val_i};
        end else begin : g_trunc
            assign ext_o = val_i[OUT_W-1:0];
        end
    endgenerate
endmodule

// File: rtl/prod_redund_reg.sv
module prod_redund_reg
    import prod_pkg::*;
#(
    parameter int ALU_W = 64
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clr_i,
    input  logic                wr_i,
    input  logic [FIELD_W-1:0]  wr_lo_i,
    input  logic [FIELD_W-1:0]  wr_mida_i,
    input  logic [FIELD_W-1:0]  wr_hi_i,
    input  logic [FIELD_W-1:0]  wr_midb_i,
    output logic [FIELD_W-1:0]  fld_lo_o,
    output logic [FIELD_W-1:0]  fld_mida_o,
    output logic [FIELD_W-1:0]  fld_hi_o,
    output logic [FIELD_W-1:0]  fld_midb_o,
    output logic [PACK_W-1:0]   packed_o,
    output logic [ALU_W-1:0]    src_wide_o,
    output logic [ALU_W-1:0]    src_half_o,
    output logic [PACK_W-1:0]   tst_base_o,
    output logic [PACK_W-1:0]   tst_corr_o
);
    prod_fields_t fld_d, fld_q;

    // Next-state selection: clear wins over load, otherwise hold.
    always_comb begin
        fld_d = fld_q;
        if (clr_i) begin
            fld_d = CLR_PATTERN;
        end else if (wr_i) begin
            fld_d.lo   = wr_lo_i;
            fld_d.mida = wr_mida_i;
            fld_d.hi   = wr_hi_i;
            fld_d.midb = wr_midb_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) fld_q <= CLR_PATTERN;
        else        fld_q <= fld_d;
    end

    assign fld_lo_o   = fld_q.lo;
    assign fld_mida_o = fld_q.mida;
    assign fld_hi_o   = fld_q.hi;
    assign fld_midb_o = fld_q.midb;

    prod_fold #(.FW(FIELD_W), .HW(HI_USED)) u_fold (
        .lo_i   (fld_q.lo),
        .mida_i (fld_q.mida),
        .hi_i   (fld_q.hi[HI_USED-1:0]),
        .midb_i (fld_q.midb),
        .base_o (tst_base_o),
        .corr_o (tst_corr_o),
        .sum_o  (packed_o)
    );

    prod_sext #(.IN_W(PACK_W), .OUT_W(ALU_W)) u_sext_wide (
        .val_i (packed_o),
        .ext_o (src_wide_o)
    );

    prod_sext #(.IN_W(HALF_W), .OUT_W(ALU_W)) u_sext_half (
        .val_i (packed_o[HALF_W-1:0]),
        .ext_o (src_half_o)
    );

    AST_CLR_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (fld_lo_o == CLR_PATTERN.lo && fld_mida_o == CLR_PATTERN.mida &&
                   fld_hi_o == CLR_PATTERN.hi && fld_midb_o == CLR_PATTERN.midb)); // R2
    AST_WR_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && !clr_i) |=> (fld_lo_o == $past(wr_lo_i) && fld_midb_o == $past(wr_midb_i))); // R3
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_i && !clr_i) |=> ($stable(fld_lo_o) && $stable(fld_mida_o) &&
                               $stable(fld_hi_o) && $stable(fld_midb_o))); // R3
    AST_CLR_FOLDS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (packed_o == '0)); // R4
    AST_WIDE_LOW_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        src_wide_o[PACK_W-1:0] == packed_o); // R6
    AST_HALF_SIGN_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        (src_half_o[ALU_W-1:HALF_W] == '0) || (&src_half_o[ALU_W-1:HALF_W-1])); // R7
endmodule

// File: tb/prod_redund_reg_bench.sv
module prod_redund_reg_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 6;

    typedef struct packed {
        logic [15:0] lo, mida, hi, midb;
        logic [39:0] pk, base, corr;
        logic [63:0] wide, half;
    } vec_t;

    localparam vec_t VECS [NV] = '{
        '{16'h0001, 16'h0002, 16'h0003, 16'h0004, 40'h03_0006_0001, 40'h03_0002_0001,
          40'h00_0004_0000, 64'h0000_0003_0006_0001, 64'h0000_0000_0006_0001},
        '{16'hFFFF, 16'hFFFF, 16'h00FF, 16'h0000, 40'hFF_FFFF_FFFF, 40'hFF_FFFF_FFFF,
          40'h0, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF},
        '{16'h0000, 16'h0000, 16'hAB80, 16'h0000, 40'h80_0000_0000, 40'h80_0000_0000,
          40'h0, 64'hFFFF_FF80_0000_0000, 64'h0},
        '{16'h1234, 16'h8000, 16'h0000, 16'h8000, 40'h01_0000_1234, 40'h00_8000_1234,
          40'h00_8000_0000, 64'h0000_0001_0000_1234, 64'h0000_0000_0000_1234},
        '{16'h0000, 16'h7FFF, 16'h0012, 16'h0001, 40'h12_8000_0000, 40'h12_7FFF_0000,
          40'h00_0001_0000, 64'h0000_0012_8000_0000, 64'hFFFF_FFFF_8000_0000},
        '{16'h0005, 16'h0001, 16'h00FF, 16'hFFFF, 40'h00_0000_0005, 40'hFF_0001_0005,
          40'h00_FFFF_0000, 64'h0000_0000_0000_0005, 64'h0000_0000_0000_0005}
    };

    logic clk = 0, rst_n = 0, clr_i = 0, wr_i = 0;
    logic [15:0] wr_lo_i = 0, wr_mida_i = 0, wr_hi_i = 0, wr_midb_i = 0;
    logic [15:0] fld_lo_o, fld_mida_o, fld_hi_o, fld_midb_o;
    logic [39:0] packed_o, tst_base_o, tst_corr_o;
    logic [63:0] src_wide_o, src_half_o;
    int n_chk = 0, n_fail = 0;
    logic [39:0] keep_pk;

    always #(CLK_PERIOD/2) clk = ~clk;

    prod_redund_reg u_prod_redund_reg (.*);

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic chk_fields(input string req, input logic [15:0] l, m, h, b);
        chk(req, {fld_lo_o, fld_mida_o, fld_hi_o, fld_midb_o}, {l, m, h, b});
    endtask

    task automatic load(input logic [15:0] l, m, h, b);
        @(negedge clk);
        wr_lo_i = l; wr_mida_i = m; wr_hi_i = h; wr_midb_i = b; wr_i = 1;
        @(negedge clk);
        wr_i = 0;
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 5000);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk_fields("R1", 16'h0000, 16'hFFF0, 16'h00FF, 16'h0010);
        chk("R4 reset packs zero", {24'h0, packed_o}, 64'h0);

        for (int i = 0; i < NV; i++) begin
            load(VECS[i].lo, VECS[i].mida, VECS[i].hi, VECS[i].midb);
            chk_fields("R3 load", VECS[i].lo, VECS[i].mida, VECS[i].hi, VECS[i].midb);
            chk("R4 R9 packed", {24'h0, packed_o}, {24'h0, VECS[i].pk});
            chk("R6 wide", src_wide_o, VECS[i].wide);
            chk("R7 half", src_half_o, VECS[i].half);
            chk("R8 base", {24'h0, tst_base_o}, {24'h0, VECS[i].base});
            chk("R8 corr", {24'h0, tst_corr_o}, {24'h0, VECS[i].corr});
        end

        // R5: changing only hi[15:8] leaves folding untouched
        load(16'h1111, 16'h2222, 16'h0033, 16'h0044);
        keep_pk = packed_o;
        load(16'h1111, 16'h2222, 16'hFF33, 16'h0044);
        chk("R5 packed", {24'h0, packed_o}, {24'h0, keep_pk});
        chk("R5 base", {24'h0, tst_base_o}, {24'h0, 40'h33_2222_1111});

        // R3: idle cycles hold
        repeat (3) @(negedge clk);
        chk_fields("R3 hold", 16'h1111, 16'h2222, 16'hFF33, 16'h0044);

        // R2: clear with simultaneous write, clear wins
        @(negedge clk);
        clr_i = 1; wr_i = 1;
        wr_lo_i = 16'hDEAD; wr_mida_i = 16'hBEEF; wr_hi_i = 16'h0001; wr_midb_i = 16'h0002;
        @(negedge clk);
        clr_i = 0; wr_i = 0;
        chk_fields("R2 clear priority", 16'h0000, 16'hFFF0, 16'h00FF, 16'h0010);
        chk("R4 clear packs zero", {24'h0, packed_o}, 64'h0);
        chk("R8 clear base", {24'h0, tst_base_o}, {24'h0, 40'hFF_FFF0_0000});
        chk("R6 clear wide", src_wide_o, 64'h0);

        // R1: reset mid-run restores pattern
        load(16'h0101, 16'h0202, 16'h0303, 16'h0404);
        @(negedge clk); rst_n = 0;
        @(negedge clk); rst_n = 1;
        chk_fields("R1 rerset", 16'h0000, 16'hFFF0, 16'h00FF, 16'h0010);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule